// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block compares the running seconds, minutes and hours bytes of a real-time clock against three alarm bytes. The comparison happens only in the cycle in which the time-keeping logic signals that an update has finished. When all three fields agree, a sticky alarm flag is set. Any alarm byte whose two top bits are both one acts as a wildcard and agrees with every value of its field. This allows alarms such as "every minute at second 30" or "once per second".

The flag is cleared when software reads the interrupt-flag register. The read strobe is given to this block. The flag value seen during the read cycle is the value returned, and the flag drops after that cycle. If a new match arrives in the same cycle as a read, the match takes precedence and the flag stays set. The flag, ANDed with the alarm-interrupt enable, forms this block's share of the summary interrupt request, and an active-high interrupt line follows that summary.

The bytes are compared raw, so the time and alarm bytes must use the same number format. The asynchronous active-low reset is synchronised internally before it is released.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm flag, its interrupt contribution and the interrupt line are all 0.
- R2: When the update strobe is high and all three alarm bytes equal their time bytes, the alarm flag is 1 from the next clock cycle.
- R3: A mismatch in any single field during an update leaves a clear flag clear.
- R4: An alarm byte with bits 7:6 equal to 2'b11 (values 0xC0 to 0xFF) matches every value of its time byte.
- R5: An alarm byte with only one of bits 7:6 set (for example 0x80 or 0x40) is not a wildcard and matches only an identical time byte.
- R6: With the update strobe low, the flag does not change on a match, and it does not change without a read.
- R7: A read strobe clears the flag from the next cycle. During the read cycle the flag still shows its earlier value.
- R8: If a read and a matching update happen in the same cycle, the flag is 1 afterwards.
- R9: The interrupt contribution and the interrupt line are 1 exactly when the flag is 1 and the alarm-interrupt enable is 1.
- R10: The flag sets on a match even when the alarm-interrupt enable is 0.
- R11: Once set, the flag stays 1 across later updates that do not match, until it is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_done_i | input | 1 | One-cycle pulse at the end of a time update |
| flag_rd_i | input | 1 | One-cycle pulse when the interrupt-flag register is read |
| alarm_en_i | input | 1 | Alarm-interrupt enable |
| time_sec_i | input | 8 | Current seconds byte |
| time_min_i | input | 8 | Current minutes byte |
| time_hr_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_req_o | output | 1 | Flag ANDed with the enable, feeding the summary request |
| irq_o | output | 1 | Active-high interrupt line |

## Verification
The hardest case to reach is a read strobe that lands in the same cycle as a matching update. In normal use, a read happens long after the update pulse. The bench drives both strobes in the same cycle, both with the flag already set and with it clear, and then checks that the flag stays 1. The wildcard boundary is covered by sweeping every field across all 256 alarm byte values against fixed time bytes. The expected match is computed arithmetically from the top two bits.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 3;
  localparam logic [1:0] WILD_TAG = 2'b11;

  typedef enum logic [1:0] {
    FLD_SEC = 2'd0,
    FLD_MIN = 2'd1,
    FLD_HR  = 2'd2
  } field_e;

  typedef logic [BYTE_W-1:0] tbyte_t;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] time_b,
  input  logic [W-1:0] alm_b,
  output logic         hit
);
  logic wild;
  logic same;

  always_comb begin
    wild = (alm_b[W-1:W-2] == rtc_alarm_pkg::WILD_TAG);
    same = (alm_b == time_b);
    hit  = wild | same;
  end

  // R5: a hit on a non-wildcard byte needs an exact match
  always_comb begin
    if (!(alm_b[W-1] & alm_b[W-2])) begin
      a_r5_exact_only: assert (!hit || (alm_b == time_b));
    end
  end
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_done,
  input  logic all_hit,
  input  logic rd_stb,
  output logic flag_q
);
  logic set_now;
  logic flag_d;
  logic flag_en;

  always_comb begin
    set_now = upd_done & all_hit;
    flag_en = set_now | rd_stb;
    flag_d  = set_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  a_r2_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && all_hit) |=> flag_q);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_done && !rd_stb) |=> $stable(flag_q));
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(upd_done && all_hit)) |=> !flag_q);
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(upd_done && all_hit));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int BYTE_W      = rtc_alarm_pkg::BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_done_i,
  input  logic              flag_rd_i,
  input  logic              alarm_en_i,
  input  logic [BYTE_W-1:0] time_sec_i,
  input  logic [BYTE_W-1:0] time_min_i,
  input  logic [BYTE_W-1:0] time_hr_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hr_i,
  output logic              alarm_flag_o,
  output logic              alarm_req_o,
  output logic              irq_o
);
  localparam int NF = rtc_alarm_pkg::NUM_FIELDS;

  logic              rst_int_n;
  logic [BYTE_W-1:0] time_v [NF];
  logic [BYTE_W-1:0] alm_v  [NF];
  logic [NF-1:0]     hits;
  logic              all_hit;
  logic              flag_q;
  logic              req_vec;

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    time_v[rtc_alarm_pkg::FLD_SEC] = time_sec_i;
    time_v[rtc_alarm_pkg::FLD_MIN] = time_min_i;
    time_v[rtc_alarm_pkg::FLD_HR]  = time_hr_i;
    alm_v[rtc_alarm_pkg::FLD_SEC]  = alm_sec_i;
    alm_v[rtc_alarm_pkg::FLD_MIN]  = alm_min_i;
    alm_v[rtc_alarm_pkg::FLD_HR]   = alm_hr_i;
  end

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    rtc_alarm_field_cmp #(.W(BYTE_W)) u_cmp (
      .time_b (time_v[g]),
      .alm_b  (alm_v[g]),
      .hit    (hits[g])
    );
  end

  assign all_hit = &hits;

  rtc_alarm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_done (upd_done_i),
    .all_hit  (all_hit),
    .rd_stb   (flag_rd_i),
    .flag_q   (flag_q)
  );

  always_comb begin
    req_vec      = flag_q & alarm_en_i;
    alarm_flag_o = flag_q;
    alarm_req_o  = req_vec;
    irq_o        = req_vec;
  end

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (alarm_flag_o && alarm_en_i));
  a_r4_all_wild_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_done_i && (&alm_sec_i[BYTE_W-1:BYTE_W-2]) && (&alm_min_i[BYTE_W-1:BYTE_W-2])
     && (&alm_hr_i[BYTE_W-1:BYTE_W-2])) |=> alarm_flag_o);
  a_r8_match_beats_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_rd_i && upd_done_i && all_hit) |=> alarm_flag_o);
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic upd, rd, en;
  logic [7:0] ts, tm, th, as_, am, ah;
  logic flag, req, irq;
  int checks = 0;
  int fails  = 0;
  logic exp_flag;

  always #2 clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .upd_done_i(upd), .flag_rd_i(rd), .alarm_en_i(en),
    .time_sec_i(ts), .time_min_i(tm), .time_hr_i(th),
    .alm_sec_i(as_), .alm_min_i(am), .alm_hr_i(ah),
    .alarm_flag_o(flag), .alarm_req_o(req), .irq_o(irq)
  );

  function automatic logic fmatch(input logic [7:0] a, input logic [7:0] t);
    return (a >= 8'hC0) || (a == t);
  endfunction

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // one cycle with given strobes; model updated; check after edge
  task automatic step(input logic u, input logic r, input string rq);
    logic m;
    upd = u; rd = r;
    m = fmatch(as_, ts) && fmatch(am, tm) && fmatch(ah, th);
    if (r) chk({rq, " read value"}, flag, exp_flag);
    @(negedge clk);
    exp_flag = (u && m) ? 1'b1 : (r ? 1'b0 : exp_flag);
    upd = 1'b0; rd = 1'b0;
    chk(rq, flag, exp_flag);
    chk({rq, " R9"}, irq, exp_flag & en);
    chk({rq, " R9 req"}, req, exp_flag & en);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd = 0; rd = 0; en = 1;
    ts = 8'h12; tm = 8'h34; th = 8'h05; as_ = 8'h00; am = 8'h00; ah = 8'h00;
    exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 flag", flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flag after release", flag, 1'b0);

    // R2: exact match
    as_ = 8'h12; am = 8'h34; ah = 8'h05;
    step(1'b0, 1'b0, "R6 no tick");
    step(1'b1, 1'b0, "R2 exact");
    // R11: sticky over nonmatching updates
    ts = 8'h13;
    step(1'b1, 1'b0, "R11 sticky");
    step(1'b0, 1'b0, "R11 idle");
    // R7 read clears
    step(1'b0, 1'b1, "R7 read");
    // R8 read and match together, flag clear then set
    ts = 8'h12;
    step(1'b1, 1'b1, "R8 clear flag");
    step(1'b1, 1'b1, "R8 set flag");
    step(1'b0, 1'b1, "R7 clear");
    // R10 enable off
    en = 1'b0;
    step(1'b1, 1'b0, "R10 en off");
    step(1'b0, 1'b1, "R7 clear en off");
    en = 1'b1;

    // R3/R4/R5 sweep each field over all 256 alarm values
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < 256; v++) begin
        ts = 8'h12; tm = 8'h34; th = 8'h05;
        as_ = 8'h12; am = 8'h34; ah = 8'h05;
        case (f)
          0: as_ = v[7:0];
          1: am  = v[7:0];
          default: ah = v[7:0];
        endcase
        step(1'b1, 1'b0, (v >= 8'hC0) ? "R4 wildcard" :
             ((v == 8'h80 || v == 8'h40) ? "R5 single top bit" : "R3 field sweep"));
        step(1'b0, 1'b1, "R7 sweep clear");
      end
    end

    // R4: all wildcards against varying time
    as_ = 8'hC0; am = 8'hFF; ah = 8'hD5;
    for (int s = 0; s < 60; s += 7) begin
      ts = s[7:0]; tm = 8'(59 - s); th = 8'(s % 24);
      step(1'b1, 1'b0, "R4 all wild");
      step(1'b0, 1'b1, "R7 clear");
    end
    // R5: 0x80 vs time 0x00
    as_ = 8'h80; am = 8'hC0; ah = 8'hC0; ts = 8'h00;
    step(1'b1, 1'b0, "R5 0x80 no match");
    ts = 8'h80;
    step(1'b1, 1'b0, "R5 0x80 exact");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule